// File: doc/BRIEF.md
# Link Detect and Polling Sequencer

This block is the first stage of a serial link training state machine. After reset it waits in a quiet substate. It then probes for a far-end receiver, and after that it runs the polling handshake. In that handshake it asks the transmitter for training sets and watches the decoded sets that arrive on each lane. When both sides have shown they are ready, it hands the link to the configuration stage with a one-cycle pulse. The block covers any number of lanes. All timeouts are given as counts of an external time-base tick, so a simulation can use short windows.

For every decoded ordered set, each lane supplies a strobe with three qualifiers: the set type (TS1 or TS2), a flag that says both number fields held PAD, and the compliance-receive bit. The transmitter pulses `tx_done` each time it finishes one requested set. The block uses these pulses to count sets sent. The receiver-present flags are captured at the moment the probe succeeds. Only the lanes captured then take part in any later decision.

Top module: `link_poll_seq`

## Requirements
- R1: A synchronous reset puts `state` at 0 (quiet), drives `tx_os` to 0 (none) and holds `cfg_go` low.
- R2: From quiet (state 0), the block moves to probe (state 1) when the quiet timer reaches QUIET_TICKS ticks, or on the first cycle that any `ei_exit` bit is high.
- R3: In probe, one cycle decides the outcome. If any `rx_det` bit is set, the block goes to polling-active (state 2) and captures `rx_det` as the detected-lane mask. Otherwise it returns to quiet.
- R4: Polling-active requests TS1 (`tx_os`=1). It advances to polling-config (state 3) once at least MIN_TS1 sets have been sent and every detected lane has RUN_LEN consecutive qualifying sets. In this substate a qualifying set is TS1 or TS2 with PAD set and the compliance bit clear. Any other set clears the run on that lane.
- R5: When the polling-active timer reaches ACT_TICKS, the block goes to polling-config if some detected lane holds a full run and every detected lane has seen an electrical-idle exit. Failing that, it goes to compliance (state 4) if a set with the compliance bit arrived on a detected lane. Otherwise it goes to quiet.
- R6: `enter_cmp` high in polling-active sends the block to compliance at once. This takes priority over every other exit.
- R7: Compliance requests the compliance pattern (`tx_os`=3). If compliance was entered through `enter_cmp`, it returns to polling-active when `enter_cmp` is low. If it was entered by timeout, it returns when a detected lane receives a set with the compliance bit clear.
- R8: Polling-config requests TS2 (`tx_os`=2). Here only TS2 with PAD set and the compliance bit clear qualifies. Once some detected lane holds RUN_LEN in a row, and MIN_TS2 sets have been sent since the cycle after the first TS2 arrived on a detected lane, the block pulses `cfg_go` for one cycle and enters the handed-over state (state 5, `tx_os`=0). It stays there until reset.
- R9: When the polling-config timer reaches CFG_TICKS before the exit in R8 is met, the block returns to quiet.
- R10: Every substate change clears the timer, the sent count, the lane runs and the sticky flags. Lanes outside the detected mask have no effect on any decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Time-base strobe that advances timers |
| rx_det | input | LANES | Receiver present, per lane |
| ei_exit | input | LANES | Electrical-idle exit seen, per lane |
| os_vld | input | LANES | Decoded ordered set strobe, per lane |
| os_ts2 | input | LANES | Set type: 1 = TS2, 0 = TS1 |
| os_pad | input | LANES | Link and lane number fields both PAD |
| os_cmp | input | LANES | Compliance-receive bit of the set |
| enter_cmp | input | 1 | Force compliance request |
| tx_done | input | 1 | One requested set finished transmitting |
| tx_os | output | 2 | Request: 0 none, 1 TS1, 2 TS2, 3 compliance |
| state | output | 3 | Substate: 0 quiet, 1 probe, 2 poll-active, 3 poll-config, 4 compliance, 5 handed over |
| cfg_go | output | 1 | One-cycle pulse on exit to configuration |

## Verification
The bench goes after four corner cases. In the first, a non-qualifying set lands in the middle of a run. A design that failed to clear the run would advance too early. In the second, polling-active times out with only one of several lanes ready. The design must take the rescue path to polling-config only when every detected lane has seen an idle exit, and must take the compliance or quiet fallback otherwise. In the third, the block leaves compliance and re-enters polling-active. A design that kept the old TS1 count across that change would skip the required count of sent sets. In the fourth, undetected lanes are fed compliance-flagged, non-PAD sets. A design that failed to mask them would stall or wrongly enter compliance.

// File: rtl/link_poll_seq.sv
module link_poll_seq #(
  parameter int LANES       = 4,
  parameter int QUIET_TICKS = 12000,
  parameter int ACT_TICKS   = 24000,
  parameter int CFG_TICKS   = 48000,
  parameter int MIN_TS1     = 1024,
  parameter int MIN_TS2     = 16,
  parameter int RUN_LEN     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [LANES-1:0] rx_det,
  input  logic [LANES-1:0] ei_exit,
  input  logic [LANES-1:0] os_vld,
  input  logic [LANES-1:0] os_ts2,
  input  logic [LANES-1:0] os_pad,
  input  logic [LANES-1:0] os_cmp,
  input  logic             enter_cmp,
  input  logic             tx_done,
  output logic [1:0]       tx_os,
  output logic [2:0]       state,
  output logic             cfg_go
);
  localparam int TA   = QUIET_TICKS > ACT_TICKS ? QUIET_TICKS : ACT_TICKS;
  localparam int TMAX = TA > CFG_TICKS ? TA : CFG_TICKS;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int CMAX = MIN_TS1 > MIN_TS2 ? MIN_TS1 : MIN_TS2;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int RW   = $clog2(RUN_LEN + 1);

  localparam logic [2:0] S_QUIET = 3'd0;
  localparam logic [2:0] S_PROBE = 3'd1;
  localparam logic [2:0] S_PACT  = 3'd2;
  localparam logic [2:0] S_PCFG  = 3'd3;
  localparam logic [2:0] S_PCMP  = 3'd4;
  localparam logic [2:0] S_DONE  = 3'd5;

  logic [2:0]       nxt;
  logic [TW-1:0]    timer, lim;
  logic [CW-1:0]    sent, cap;
  logic [LANES-1:0] mask, met, ei_seen, cmp_seen, qual;
  logic             ts2_seen, cause_rx, tmo;

  wire any_met  = |(met & mask);
  wire all_met  = &(met | ~mask);
  wire all_ei   = &(ei_seen | ~mask);
  wire rx_clear = |(os_vld & ~os_cmp & mask);
  wire cmp_any  = |(cmp_seen & mask);
  wire moving   = nxt != state;

  always_comb begin
    case (state)
      S_QUIET: lim = TW'(QUIET_TICKS);
      S_PACT:  lim = TW'(ACT_TICKS);
      S_PCFG:  lim = TW'(CFG_TICKS);
      default: lim = '0;
    endcase
  end

  assign tmo  = timer == lim;
  assign cap  = (state == S_PACT) ? CW'(MIN_TS1) : CW'(MIN_TS2);
  assign qual = os_pad & ~os_cmp & ((state == S_PCFG) ? os_ts2 : {LANES{1'b1}});

  always_comb begin
    case (state)
      S_PACT:  tx_os = 2'd1;
      S_PCFG:  tx_os = 2'd2;
      S_PCMP:  tx_os = 2'd3;
      default: tx_os = 2'd0;
    endcase
  end

  always_comb begin
    nxt = state;
    case (state)
      S_QUIET: if (|ei_exit || tmo) nxt = S_PROBE;
      S_PROBE: nxt = |rx_det ? S_PACT : S_QUIET;
      S_PACT: begin
        if (enter_cmp)                            nxt = S_PCMP;
        else if (sent >= CW'(MIN_TS1) && all_met) nxt = S_PCFG;
        else if (tmo) begin
          if (any_met && all_ei) nxt = S_PCFG;
          else if (cmp_any)      nxt = S_PCMP;
          else                   nxt = S_QUIET;
        end
      end
      S_PCFG: begin
        if (any_met && sent >= CW'(MIN_TS2)) nxt = S_DONE;
        else if (tmo)                        nxt = S_QUIET;
      end
      S_PCMP: if (cause_rx ? rx_clear : !enter_cmp) nxt = S_PACT;
      default: nxt = state;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_QUIET;
      cfg_go   <= 1'b0;
      mask     <= '0;
      cause_rx <= 1'b0;
    end else begin
      state  <= nxt;
      cfg_go <= (state == S_PCFG) && (nxt == S_DONE);
      if (state == S_PROBE && nxt == S_PACT) mask <= rx_det;
      if (nxt == S_PCMP && state != S_PCMP)  cause_rx <= !enter_cmp;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || moving) begin
      timer    <= '0;
      sent     <= '0;
      ei_seen  <= '0;
      cmp_seen <= '0;
      ts2_seen <= 1'b0;
    end else begin
      if (tick && !tmo) timer <= timer + 1'b1;
      if (tx_done && sent != cap && (state == S_PACT || (state == S_PCFG && ts2_seen)))
        sent <= sent + 1'b1;
      ei_seen  <= ei_seen | ei_exit;
      cmp_seen <= cmp_seen | (os_vld & os_cmp);
      if (|(os_vld & os_ts2 & mask)) ts2_seen <= 1'b1;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [RW-1:0] run;
    always_ff @(posedge clk) begin
      if (rst || moving)  run <= '0;
      else if (os_vld[i]) run <= !qual[i] ? '0 : (run == RW'(RUN_LEN) ? run : run + 1'b1);
    end
    assign met[i] = run == RW'(RUN_LEN);
  end

  assert_probe_order_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_PROBE && !$past(rst)) |-> $past(state) == S_QUIET);

  assert_poll_needs_rx_R3: assert property (@(posedge clk) disable iff (rst)
    (state == S_PACT && $past(state) == S_PROBE && !$past(rst)) |-> $past(|rx_det));

  assert_cfg_needs_run_R4: assert property (@(posedge clk) disable iff (rst)
    (state == S_PCFG && $past(state) == S_PACT && !$past(rst)) |-> $past(any_met));

  assert_cmp_exit_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == S_PCMP && state != S_PCMP && !$past(rst)) |-> state == S_PACT);

  assert_go_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_go |-> (state == S_DONE && $past(state) == S_PCFG));

  assert_done_hold_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == S_DONE && !$past(rst)) |-> (state == S_DONE && !cfg_go));

  assert_cfg_exit_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == S_PCFG && !$past(rst) && state != S_PCFG) |-> (state == S_DONE || state == S_QUIET));
endmodule

// File: tb/tb_link_poll_seq.sv
`timescale 1ns/1ps
module tb_link_poll_seq;
  localparam int L = 4, QT = 6, AT = 60, CT = 80, M1 = 20, M2 = 16, RL = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, tick = 1'b0, enter_cmp = 1'b0, tx_done = 1'b0;
  logic [L-1:0] rx_det = '0, ei_exit = '0, os_vld = '0, os_ts2 = '0, os_pad = '0, os_cmp = '0;
  logic [1:0] tx_os;
  logic [2:0] state;
  logic cfg_go;

  link_poll_seq #(.LANES(L), .QUIET_TICKS(QT), .ACT_TICKS(AT), .CFG_TICKS(CT),
                  .MIN_TS1(M1), .MIN_TS2(M2), .RUN_LEN(RL)) dut (
    .clk(clk), .rst(rst), .tick(tick), .rx_det(rx_det), .ei_exit(ei_exit),
    .os_vld(os_vld), .os_ts2(os_ts2), .os_pad(os_pad), .os_cmp(os_cmp),
    .enter_cmp(enter_cmp), .tx_done(tx_done), .tx_os(tx_os), .state(state), .cfg_go(cfg_go));

  int total = 0, bad = 0, cyc = 0, mode = 1;
  bit finished = 0;
  logic [L-1:0] g_lanes = '0, g_noise = '0, g_det = '0, g_ei = '0;
  logic g_ts2 = 0, g_cmp = 0, g_bad = 0, g_txd = 0, g_ec = 0, g_rst = 1, r_ec = 0;

  int ms = 0, mgo = 0, mtimer = 0, msent = 0, mts2 = 0, mcause = 0;
  int mrun [L];
  logic [L-1:0] mmask = '0, mei = '0, mcmp = '0;
  int nx, lim, cap;
  bit anym, allm, alle, tmo, rxclr, q;

  task automatic chk(string tag, bit ok, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic mclr();
    mtimer = 0; msent = 0; mts2 = 0; mei = '0; mcmp = '0;
    for (int i = 0; i < L; i++) mrun[i] = 0;
  endtask

  function automatic string stag(int s);
    case (s)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      4: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic int exp_tx(int s);
    case (s)
      2: return 1;
      3: return 2;
      4: return 3;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ms = 0; mgo = 0; mmask = '0; mcause = 0; mclr();
    end else begin
      anym = 0; allm = 1; alle = 1; rxclr = 0;
      for (int i = 0; i < L; i++) if (mmask[i]) begin
        if (mrun[i] == RL) anym = 1; else allm = 0;
        if (!mei[i]) alle = 0;
        if (os_vld[i] && !os_cmp[i]) rxclr = 1;
      end
      lim = (ms == 0) ? QT : (ms == 2) ? AT : (ms == 3) ? CT : 0;
      tmo = (mtimer == lim);
      nx = ms;
      case (ms)
        0: if (ei_exit != 0 || tmo) nx = 1;
        1: nx = (rx_det != 0) ? 2 : 0;
        2: if (enter_cmp) nx = 4;
           else if (msent >= M1 && allm) nx = 3;
           else if (tmo) nx = (anym && alle) ? 3 : ((mcmp & mmask) != 0) ? 4 : 0;
        3: if (anym && msent >= M2) nx = 5;
           else if (tmo) nx = 0;
        4: if (mcause != 0 ? rxclr : !enter_cmp) nx = 2;
        default: nx = ms;
      endcase
      mgo = (ms == 3 && nx == 5) ? 1 : 0;
      if (ms == 1 && nx == 2) mmask = rx_det;
      if (nx == 4 && ms != 4) mcause = enter_cmp ? 0 : 1;
      if (nx != ms) mclr();
      else begin
        if (tick && !tmo) mtimer++;
        cap = (ms == 2) ? M1 : M2;
        if (tx_done && msent != cap && (ms == 2 || (ms == 3 && mts2 != 0))) msent++;
        for (int i = 0; i < L; i++) if (os_vld[i]) begin
          q = os_pad[i] && !os_cmp[i] && (ms != 3 || os_ts2[i]);
          mrun[i] = q ? ((mrun[i] == RL) ? RL : mrun[i] + 1) : 0;
        end
        mei = mei | ei_exit;
        mcmp = mcmp | (os_vld & os_cmp);
        if ((os_vld & os_ts2 & mmask) != 0) mts2 = 1;
      end
      ms = nx;
    end
  end

  always @(negedge clk) if (!finished) begin
    cyc++;
    if (cyc > 3) begin
      chk(stag(ms), state === 3'(ms), int'(state), ms);
      chk(stag(ms), tx_os === 2'(exp_tx(ms)), int'(tx_os), exp_tx(ms));
      chk("R8", cfg_go === 1'(mgo), int'(cfg_go), mgo);
    end
    if (mode == 2) begin
      rst = ($urandom % 300) == 0;
      rx_det = 4'($urandom);
      ei_exit = (($urandom % 8) == 0) ? 4'($urandom) : '0;
      os_vld = 4'($urandom);
      os_ts2 = 4'($urandom);
      os_pad = 4'($urandom) | 4'($urandom) | 4'($urandom);
      os_cmp = 4'($urandom) & 4'($urandom) & 4'($urandom);
      if (($urandom % 40) == 0) r_ec = ~r_ec;
      enter_cmp = r_ec;
      tx_done = 1'($urandom);
      tick = 1'($urandom);
    end else begin
      rst = g_rst; rx_det = g_det; ei_exit = g_ei; tick = cyc[0];
      tx_done = g_txd; enter_cmp = g_ec;
      for (int i = 0; i < L; i++) begin
        os_vld[i] = ((cyc % 2 == 0) && g_lanes[i]) || g_noise[i];
        os_ts2[i] = g_ts2;
        os_pad[i] = !(g_noise[i] || (g_bad && cyc % 13 == 0));
        os_cmp[i] = g_noise[i] || g_cmp;
      end
    end
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_st(int s, int lmt, string tag);
    int n = 0;
    while (state !== 3'(s) && n < lmt) begin
      @(negedge clk);
      n++;
    end
    chk(tag, state === 3'(s), int'(state), s);
  endtask

  task automatic do_reset();
    g_lanes = '0; g_noise = '0; g_det = '0; g_ei = '0;
    g_ts2 = 0; g_cmp = 0; g_bad = 0; g_txd = 0; g_ec = 0;
    g_rst = 1;
    repeat (3) @(negedge clk);
    g_rst = 0;
    @(negedge clk);
  endtask

  task automatic to_poll(logic [L-1:0] det);
    g_det = det; g_ei = 4'b0001;
    wait_st(1, 4, "R2");
    g_ei = '0;
    wait_st(2, 4, "R3");
  endtask

  initial begin
    do_reset();
    chk("R1", state === 3'd0, int'(state), 0);
    chk("R1", tx_os === 2'd0, int'(tx_os), 0);
    chk("R1", cfg_go === 1'b0, int'(cfg_go), 0);
    wait_st(1, 40, "R2");
    wait_st(0, 4, "R3");

    do_reset();
    to_poll(4'b0011);
    chk("R4", tx_os === 2'd1, int'(tx_os), 1);
    g_lanes = 4'b0011; g_txd = 1; g_bad = 1;
    wait_st(3, 80, "R4");
    chk("R8", tx_os === 2'd2, int'(tx_os), 2);
    g_bad = 0; g_ts2 = 1;
    while (state === 3'd3) @(negedge clk);
    chk("R8", state === 3'd5, int'(state), 5);
    chk("R8", cfg_go === 1'b1, int'(cfg_go), 1);
    @(negedge clk);
    chk("R8", cfg_go === 1'b0, int'(cfg_go), 0);

    do_reset();
    to_poll(4'b1111);
    g_ei = 4'b1111; g_lanes = 4'b0001; g_txd = 1;
    wait_st(3, 140, "R5");
    g_ei = '0; g_lanes = '0;
    wait_st(0, 180, "R9");

    do_reset();
    to_poll(4'b0011);
    g_lanes = 4'b0011; g_cmp = 1;
    wait_st(4, 140, "R5");
    chk("R7", tx_os === 2'd3, int'(tx_os), 3);
    g_cmp = 0;
    wait_st(2, 6, "R7");

    do_reset();
    to_poll(4'b0011);
    g_det = '0;
    wait_st(0, 140, "R5");

    do_reset();
    to_poll(4'b0011);
    g_lanes = 4'b0011; g_txd = 1; g_ec = 1;
    wait_st(4, 4, "R6");
    repeat (10) @(negedge clk);
    chk("R7", state === 3'd4, int'(state), 4);
    g_ec = 0;
    wait_st(2, 4, "R7");
    repeat (10) @(negedge clk);
    chk("R10", state === 3'd2, int'(state), 2);
    wait_st(3, 60, "R4");

    do_reset();
    to_poll(4'b0001);
    g_lanes = 4'b0001; g_noise = 4'b1110; g_txd = 1;
    wait_st(3, 40, "R10");
    g_noise = '0;

    do_reset();
    mode = 2;
    repeat (4000) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule